// File: doc/BRIEF.md
# LR/SC Reservation Monitor

This block keeps the load-reserved/store-conditional reservation for one hart, outside the core. The core sends one-cycle strobes: a load-reserved strobe with its address, a store-conditional strobe with its address, an atomic-memory-operation strobe, a trap strobe and an external write of a validity value. The trap strobe covers any exception or interrupt taken and any exception-return instruction. The monitor holds one stored address and a valid flag.

When a store-conditional arrives, the block compares addresses at a granule's resolution. It returns pass or fail combinationally, in the same cycle, so the core can finish the instruction without a stall. Every store-conditional ends the reservation, whatever its result. A read view of the reservation is always driven. It shows the stored address while a reservation is held and all ones while none is held.

Top module: `resv_monitor`

## Requirements
- R1: A load-reserved strobe makes the reservation active from the next cycle on, and `resv_addr_o` then shows the full address that came with the strobe.
- R2: A store-conditional passes (`sc_pass_o` high in the same cycle as `sc_i`) when a reservation is active, no invalidating event arrives in that cycle, and the address bits from log2(GRANULE_BYTES) upward match the stored address. With the default 64-byte granule, bits 5..0 are ignored.
- R3: A store-conditional fails when no reservation is active, or when its address falls in a different granule.
- R4: After any store-conditional, pass or fail, the reservation is inactive from the next cycle, unless a load-reserved strobe arrives in the same cycle.
- R5: A trap strobe invalidates the reservation. A store-conditional in the same cycle as a trap strobe fails.
- R6: An external write (`ext_wr_i` high) with `ext_val_i` = 0 invalidates the reservation, and a store-conditional in that cycle fails. A write with `ext_val_i` = 1 leaves the reservation and its address unchanged.
- R7: With AMO_ABORT = 0 (the default), an AMO strobe leaves the reservation and its address unchanged. With AMO_ABORT = 1, it acts as an invalidating event.
- R8: While no reservation is active, `resv_addr_o` reads all ones and `resv_active_o` is low.
- R9: A load-reserved strobe during an active reservation replaces the stored address. A load-reserved strobe in the same cycle as an invalidating event or a store-conditional leaves the new reservation active.
- R10: After reset, `resv_active_o` is low and `resv_addr_o` reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lr_i | input | 1 | Load-reserved strobe |
| lr_addr_i | input | ADDR_W | Load-reserved address |
| sc_i | input | 1 | Store-conditional strobe |
| sc_addr_i | input | ADDR_W | Store-conditional address |
| amo_i | input | 1 | Atomic memory operation strobe |
| trap_i | input | 1 | Exception, interrupt or exception-return strobe |
| ext_wr_i | input | 1 | External write strobe for the validity value |
| ext_val_i | input | 1 | Value written; 0 invalidates |
| sc_pass_o | output | 1 | Store-conditional result, same cycle as `sc_i` |
| resv_active_o | output | 1 | Reservation held |
| resv_addr_o | output | ADDR_W | Stored address, or all ones when idle |

## Verification
`sc_pass_o` is due in the cycle of the strobe itself. The bench drives the strobes just after a falling edge and samples the result 1 ns later, before the next rising edge. `resv_active_o` and `resv_addr_o` change one rising edge after the event. They are sampled at the following falling edge, before new inputs are applied, against a behavioural reference that advances on every rising edge. Directed cases cover the granule boundary (bit 5 versus bit 6), same-cycle collisions of SC, LR, trap and external writes, and AMO strobes. A long random phase follows.

// File: rtl/resv_pkg.sv
package resv_pkg;
    localparam int unsigned RESV_AW_DEF      = 40;
    localparam int unsigned RESV_GRANULE_DEF = 64;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_LR   = 2'd1,
        EV_KILL = 2'd2
    } resv_ev_e;
endpackage

// File: rtl/resv_granule_match.sv
module resv_granule_match #(
    parameter int unsigned W   = 40,
    parameter int unsigned LSB = 6
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         hit_o
);
    assign hit_o = (a_i[W-1:LSB] == b_i[W-1:LSB]);

    generate
        if (LSB > 0) begin : g_low
            logic unused_low;
            assign unused_low = ^{a_i[LSB-1:0], b_i[LSB-1:0]};
        end
    endgenerate
endmodule

// File: rtl/resv_readout.sv
module resv_readout #(
    parameter int unsigned W = 40
) (
    input  logic         valid_i,
    input  logic [W-1:0] addr_i,
    output logic [W-1:0] view_o
);
    always_comb begin
        view_o = '1;
        if (valid_i) view_o = addr_i;
    end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int unsigned ADDR_W        = RESV_AW_DEF,
    parameter int unsigned GRANULE_BYTES = RESV_GRANULE_DEF,
    parameter bit          AMO_ABORT     = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lr_i,
    input  logic [ADDR_W-1:0] lr_addr_i,
    input  logic              sc_i,
    input  logic [ADDR_W-1:0] sc_addr_i,
    input  logic              amo_i,
    input  logic              trap_i,
    input  logic              ext_wr_i,
    input  logic              ext_val_i,
    output logic              sc_pass_o,
    output logic              resv_active_o,
    output logic [ADDR_W-1:0] resv_addr_o
);
    localparam int unsigned GRAN_LSB = $clog2(GRANULE_BYTES);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } state_t;

    state_t   s_d, s_q;
    resv_ev_e ev_d;
    logic     amo_kill_d;
    logic     kill_d;
    logic     gran_hit_d;

    generate
        if (AMO_ABORT) begin : g_amo_abort
            assign amo_kill_d = amo_i;
        end else begin : g_amo_keep
            assign amo_kill_d = amo_i & 1'b0;
        end
    endgenerate

    assign kill_d = trap_i | (ext_wr_i & ~ext_val_i) | amo_kill_d;

    resv_granule_match #(
        .W   (ADDR_W),
        .LSB (GRAN_LSB)
    ) i_match (
        .a_i   (sc_addr_i),
        .b_i   (s_q.addr),
        .hit_o (gran_hit_d)
    );

    always_comb begin
        s_d  = s_q;
        ev_d = EV_NONE;
        if (lr_i)                ev_d = EV_LR;
        else if (sc_i || kill_d) ev_d = EV_KILL;
        case (ev_d)
            EV_LR: begin
                s_d.valid = 1'b1;
                s_d.addr  = lr_addr_i;
            end
            EV_KILL: s_d.valid = 1'b0;
            default: ;
        endcase
    end

    assign sc_pass_o = sc_i & s_q.valid & gran_hit_d & ~kill_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{valid: 1'b0, addr: '0};
        else         s_q <= s_d;
    end

    assign resv_active_o = s_q.valid;

    resv_readout #(
        .W (ADDR_W)
    ) i_readout (
        .valid_i (s_q.valid),
        .addr_i  (s_q.addr),
        .view_o  (resv_addr_o)
    );
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int unsigned ADDR_W        = 40,
    parameter int unsigned GRANULE_BYTES = 64,
    parameter bit          AMO_ABORT     = 1'b0
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              lr_i,
    input logic [ADDR_W-1:0] lr_addr_i,
    input logic              sc_i,
    input logic [ADDR_W-1:0] sc_addr_i,
    input logic              amo_i,
    input logic              trap_i,
    input logic              ext_wr_i,
    input logic              ext_val_i,
    input logic              sc_pass_o,
    input logic              resv_active_o,
    input logic [ADDR_W-1:0] resv_addr_o
);
    localparam int unsigned GL = $clog2(GRANULE_BYTES);

    p_lr_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lr_i |=> (resv_active_o && resv_addr_o == $past(lr_addr_i)));

    p_pass_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sc_pass_o |-> (resv_addr_o[ADDR_W-1:GL] == sc_addr_i[ADDR_W-1:GL]));

    p_idle_fail_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sc_i && !resv_active_o) |-> !sc_pass_o);

    p_sc_ends_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sc_i && !lr_i) |=> !resv_active_o);

    p_trap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i |-> !sc_pass_o);

    p_trap_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_i && !lr_i) |=> !resv_active_o);

    p_ext_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ext_wr_i && !ext_val_i && !lr_i) |=> !resv_active_o);

    p_amo_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!AMO_ABORT && amo_i && resv_active_o && !lr_i && !sc_i && !trap_i
         && !(ext_wr_i && !ext_val_i)) |=> (resv_active_o && $stable(resv_addr_o)));

    p_idle_ones_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !resv_active_o |-> (resv_addr_o == {ADDR_W{1'b1}}));
endmodule

bind resv_monitor resv_monitor_chk #(
    .ADDR_W        (ADDR_W),
    .GRANULE_BYTES (GRANULE_BYTES),
    .AMO_ABORT     (AMO_ABORT)
) i_resv_monitor_chk (.*);

// File: tb/test_resv_monitor.sv
`timescale 1ns/1ps
module test_resv_monitor;
    localparam int AW = 40;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          lr_i = 0, sc_i = 0, amo_i = 0, trap_i = 0, ext_wr_i = 0, ext_val_i = 0;
    logic [AW-1:0] lr_addr_i = '0, sc_addr_i = '0;
    logic          sc_pass_o, resv_active_o;
    logic [AW-1:0] resv_addr_o;

    int  n_cmp = 0, n_bad = 0;
    bit  done = 0;

    bit            ref_valid = 0;
    logic [AW-1:0] ref_addr = '0;

    always #4 clk_i = ~clk_i;

    resv_monitor i_resv_monitor (.*);

    task automatic chk(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // tag names the requirement the stimulus targets
    task automatic step(string tag, bit lr, logic [AW-1:0] la, bit sc, logic [AW-1:0] sa,
                        bit amo, bit trap, bit ew, bit ev);
        bit kill, pass;
        @(negedge clk_i);
        chk(ref_valid ? "R1" : "R8", "active", {39'd0, resv_active_o}, {39'd0, ref_valid});
        chk(ref_valid ? "R1" : "R8", "view", resv_addr_o, ref_valid ? ref_addr : {AW{1'b1}});
        lr_i = lr; lr_addr_i = la; sc_i = sc; sc_addr_i = sa;
        amo_i = amo; trap_i = trap; ext_wr_i = ew; ext_val_i = ev;
        #1;
        kill = trap || (ew && !ev);
        pass = sc && ref_valid && ((sa >> 6) == (ref_addr >> 6)) && !kill;
        if (sc) chk(tag, "sc_pass", {39'd0, sc_pass_o}, {39'd0, pass});
        else    chk(tag, "sc_pass idle", {39'd0, sc_pass_o}, 40'd0);
        @(posedge clk_i);
        if (lr) begin ref_valid = 1; ref_addr = la; end
        else if (sc || kill) ref_valid = 0;
    endtask

    task automatic idle(string tag);
        step(tag, 0, '0, 0, '0, 0, 0, 0, 0);
    endtask

    localparam logic [AW-1:0] A = 40'h12_3456_7880;
    localparam logic [AW-1:0] B = 40'h00_0000_1000;

    initial begin
        #20;
        // R10: reset state
        chk("R10", "active", {39'd0, resv_active_o}, 40'd0);
        chk("R10", "view", resv_addr_o, {AW{1'b1}});
        rst_ni = 1'b1;
        idle("R10");
        // R1, R2: pass with low six bits differing
        step("R1", 1, A, 0, '0, 0, 0, 0, 0);
        step("R2", 0, '0, 1, A ^ 40'h3f, 0, 0, 0, 0);
        // R4, R3: second SC fails
        step("R3", 0, '0, 1, A, 0, 0, 0, 0);
        idle("R4");
        // R3: bit 6 differs
        step("R1", 1, A, 0, '0, 0, 0, 0, 0);
        step("R3", 0, '0, 1, A ^ 40'h40, 0, 0, 0, 0);
        idle("R4");
        // R5: trap before SC; trap with SC
        step("R1", 1, A, 0, '0, 0, 0, 0, 0);
        step("R5", 0, '0, 0, '0, 0, 1, 0, 0);
        step("R5", 0, '0, 1, A, 0, 0, 0, 0);
        step("R1", 1, A, 0, '0, 0, 0, 0, 0);
        step("R5", 0, '0, 1, A, 0, 1, 0, 0);
        // R6: write of one keeps, write of zero clears, zero with SC fails
        step("R1", 1, B, 0, '0, 0, 0, 0, 0);
        step("R6", 0, '0, 0, '0, 0, 0, 1, 1);
        step("R6", 0, '0, 0, '0, 0, 0, 1, 0);
        step("R6", 0, '0, 1, B, 0, 0, 0, 0);
        step("R1", 1, B, 0, '0, 0, 0, 0, 0);
        step("R6", 0, '0, 1, B, 0, 0, 1, 0);
        // R7: AMO keeps reservation
        step("R1", 1, B, 0, '0, 0, 0, 0, 0);
        step("R7", 0, '0, 0, '0, 1, 0, 0, 0);
        step("R7", 0, '0, 1, B + 40'h8, 1, 0, 0, 0);
        // R9: replacement, LR wins over kill and SC
        step("R1", 1, A, 0, '0, 0, 0, 0, 0);
        step("R9", 1, B, 0, '0, 0, 0, 0, 0);
        step("R9", 0, '0, 1, A, 0, 0, 0, 0);
        step("R9", 1, A, 0, '0, 0, 1, 1, 0);
        step("R9", 1, B, 1, A, 0, 0, 0, 0);
        step("R2", 0, '0, 1, B, 0, 0, 0, 0);
        // R3: SC with no reservation
        step("R3", 0, '0, 1, B, 0, 0, 0, 0);
        idle("R8");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 15);
            logic [AW-1:0] a1 = (($urandom_range(0, 3)) << 6) | $urandom_range(0, 127);
            logic [AW-1:0] a2 = (($urandom_range(0, 3)) << 6) | $urandom_range(0, 127);
            step("R2", r < 3, a1, (r >= 3 && r < 7) || r == 15, a2, r == 8 || r == 9,
                 r == 10, r == 11 || r == 12, r == 12);
        end
        idle("R8");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule